// File: doc/BRIEF.md
# Codec Power and Master-Clock Select Controller

This block decides whether the digital section of a voice-band codec is awake. It also picks the clock that drives the decode path. The block samples three asynchronous inputs with a fast system clock. One input is a shared pin that is either the decode master clock or a power-down request. The other two are the encode and decode frame syncs.

The shared pin is classified by its activity:
- A pin that keeps toggling is taken as the decode master clock.
- A pin that has stayed low for long enough selects the encode clock for all timing and allows the block to wake.
- A pin that has stayed high for long enough forces power-down.

A frame-sync pulse on either direction wakes the block. If no frame-sync pulse arrives for a set idle time, the block goes back to sleep. After waking, the encode serial data driver stays disabled until the second encode frame sync arrives. The analog output driver is enabled only while the block is powered.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: After reset, `powered_o`, `dout_en_o` and `aout_en_o` are 0 and `dec_clk_sel_o` is 0.
- R2: Once the shared pin has been high with no edge for `STATIC_CYCLES` system cycles, the block powers down, and frame-sync pulses cannot power it up while the pin stays in that state. When this condition and a frame-sync edge occur in the same cycle, power-down wins.
- R3: Once the shared pin has been low with no edge for `STATIC_CYCLES` cycles, `dec_clk_sel_o` is 0 (encode clock selected), and frame-sync pulses may power the block up.
- R4: A pin that toggles with fewer than `STATIC_CYCLES` cycles between edges gives `dec_clk_sel_o` = 1 (decode clock selected), and it is never treated as a power-down request.
- R5: While the block is powered down and the pin is not static high, a rising edge on either frame sync sets `powered_o` to 1.
- R6: The block powers down once `IDLE_CYCLES` system cycles pass with no rising edge on either frame sync. Each rising edge restarts this count.
- R7: `dout_en_o` becomes 1 only at the second encode frame-sync rising edge counted since power-up. An encode pulse that causes the power-up counts as the first. Decode pulses are not counted. `dout_en_o` returns to 0 whenever the block powers down.
- R8: `aout_en_o` equals `powered_o` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dclk_pd_i | input | 1 | Shared pin: decode master clock or power-down level (asynchronous) |
| fs_enc_i | input | 1 | Encode frame sync (asynchronous) |
| fs_dec_i | input | 1 | Decode frame sync (asynchronous) |
| powered_o | output | 1 | Block is powered up |
| dec_clk_sel_o | output | 1 | 1 = decode clock from shared pin, 0 = encode clock |
| dout_en_o | output | 1 | Encode serial data driver may be enabled |
| aout_en_o | output | 1 | Analog output driver may be enabled |

## Verification
The wake-up event and the first count toward the data-enable threshold can fall in the same cycle. This happens when an encode frame sync arrives while the block is asleep: one edge both powers the block up and must count as the first encode pulse. The bench provokes this in two ways:
- An encode-only pulse is sent while the block is powered down.
- An encode pulse and a decode pulse are sent together while the block is powered down.

It then judges the result at the ports. The data enable must stay 0 after the waking pulse and must be 1 after exactly one more encode pulse.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
    // Classification of the shared decode-clock / power-down pin
    typedef enum logic [1:0] {
        PIN_HIGH  = 2'd0,
        PIN_LOW   = 2'd1,
        PIN_CLOCK = 2'd2
    } pin_mode_e;
endpackage

// File: rtl/cpc_sync.sv
module cpc_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] edge_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
        logic [1:0]   warm;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.s1   = async_i;
        r_d.s2   = r_q.s1;
        r_d.s3   = r_q.s2;
        if (r_q.warm != 2'd3) r_d.warm = r_q.warm + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lvl_o  = r_q.s2;
    // edges are masked until the pipeline holds real samples
    assign edge_o = (r_q.warm == 2'd3) ? (r_q.s2 ^ r_q.s3) : '0;
endmodule

// File: rtl/cpc_pin_class.sv
module cpc_pin_class
    import cpc_pkg::*;
#(
    parameter int STATIC_CYCLES = 256
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_lvl_i,
    input  logic      pin_edge_i,
    output pin_mode_e mode_o
);
    localparam int QW = (STATIC_CYCLES > 2) ? $clog2(STATIC_CYCLES) : 1;
    localparam logic [QW-1:0] QUIET_LAST = QW'(STATIC_CYCLES - 1);

    typedef struct packed {
        pin_mode_e     mode;
        logic [QW-1:0] quiet;
    } cls_t;

    cls_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (pin_edge_i) begin
            r_d.quiet = '0;
            r_d.mode  = PIN_CLOCK;
        end else if (r_q.quiet == QUIET_LAST) begin
            r_d.mode = pin_lvl_i ? PIN_HIGH : PIN_LOW;
        end else begin
            r_d.quiet = r_q.quiet + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode  <= PIN_HIGH;
            r_q.quiet <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mode_o = r_q.mode;

    // R4
    pin_edge_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pin_edge_i |=> (mode_o == PIN_CLOCK));
endmodule

// File: rtl/cpc_idle_timer.sv
module cpc_idle_timer #(
    parameter int IDLE_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expired_o
);
    localparam int IW = $clog2(IDLE_CYCLES + 1);
    localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_CYCLES);

    typedef struct packed {
        logic [IW-1:0] idle;
    } tmr_t;

    tmr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (restart_i)               r_d.idle = '0;
        else if (r_q.idle != IDLE_MAX) r_d.idle = r_q.idle + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.idle <= IDLE_MAX;
        else        r_q <= r_d;
    end

    assign expired_o = (r_q.idle == IDLE_MAX);

    // R6
    idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !expired_o);
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
    import cpc_pkg::*;
#(
    parameter int STATIC_CYCLES = 256,
    parameter int IDLE_CYCLES   = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dclk_pd_i,
    input  logic fs_enc_i,
    input  logic fs_dec_i,
    output logic powered_o,
    output logic dec_clk_sel_o,
    output logic dout_en_o,
    output logic aout_en_o
);
    localparam int IDX_ENC = 0;
    localparam int IDX_DEC = 1;
    localparam int IDX_PIN = 2;
    localparam logic [1:0] ENC_NEEDED = 2'd2;

    logic [2:0] lvl, edg;
    logic       enc_rise, dec_rise, any_rise, expired;
    pin_mode_e  mode;

    cpc_sync #(.W(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({dclk_pd_i, fs_dec_i, fs_enc_i}),
        .lvl_o  (lvl),
        .edge_o (edg)
    );

    assign enc_rise = edg[IDX_ENC] & lvl[IDX_ENC];
    assign dec_rise = edg[IDX_DEC] & lvl[IDX_DEC];
    assign any_rise = enc_rise | dec_rise;

    cpc_pin_class #(.STATIC_CYCLES(STATIC_CYCLES)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl_i (lvl[IDX_PIN]),
        .pin_edge_i(edg[IDX_PIN]),
        .mode_o    (mode)
    );

    cpc_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(any_rise),
        .expired_o(expired)
    );

    typedef struct packed {
        logic       up;
        logic [1:0] enc_cnt;
    } pwr_t;

    pwr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!r_q.up) begin
            r_d.enc_cnt = '0;
            if (any_rise && mode != PIN_HIGH) begin
                r_d.up      = 1'b1;
                r_d.enc_cnt = enc_rise ? 2'd1 : 2'd0;
            end
        end else if (mode == PIN_HIGH || (expired && !any_rise)) begin
            r_d.up      = 1'b0;
            r_d.enc_cnt = '0;
        end else if (enc_rise && r_q.enc_cnt != ENC_NEEDED) begin
            r_d.enc_cnt = r_q.enc_cnt + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign powered_o     = r_q.up;
    assign aout_en_o     = r_q.up;
    assign dout_en_o     = r_q.up && (r_q.enc_cnt == ENC_NEEDED);
    assign dec_clk_sel_o = (mode == PIN_CLOCK);

    // R2
    pin_high_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PIN_HIGH) |=> !powered_o);
    // R5
    fs_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!powered_o && any_rise && mode != PIN_HIGH) |=> powered_o);
    // R6
    idle_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (powered_o && expired && !any_rise) |=> !powered_o);
    // R7
    dout_after_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_en_o) |-> $past(enc_rise));
endmodule

// File: tb/codec_pwr_ctrl_test.sv
`timescale 1ns/1ps
module codec_pwr_ctrl_test;
    localparam int STATIC_CYCLES = 16;
    localparam int IDLE_CYCLES   = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_drv = 1'b0;
    logic fs_enc = 1'b0;
    logic fs_dec = 1'b0;
    logic powered, dec_sel, dout_en, aout_en;
    logic [1:0] pin_mode = 2'd0;   // 0 static low, 1 static high, 2 toggling
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    codec_pwr_ctrl #(.STATIC_CYCLES(STATIC_CYCLES), .IDLE_CYCLES(IDLE_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .dclk_pd_i(pin_drv),
        .fs_enc_i(fs_enc), .fs_dec_i(fs_dec),
        .powered_o(powered), .dec_clk_sel_o(dec_sel),
        .dout_en_o(dout_en), .aout_en_o(aout_en)
    );

    // pin driver: toggles every 4 system cycles in clock mode
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = ph + 1;
            case (pin_mode)
                2'd0: pin_drv = 1'b0;
                2'd1: pin_drv = 1'b1;
                default: if (ph % 4 == 0) pin_drv = ~pin_drv;
            endcase
        end
    end

    task automatic check(input string req, input int step, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s step %0d: actual %0b expected %0b", req, step, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulses(input int n_enc, input int n_dec);
        for (int i = 0; i < 3; i++) begin
            if (i < n_enc || i < n_dec) begin
                fs_enc = (i < n_enc);
                fs_dec = (i < n_dec);
                wait_cyc(3);
                fs_enc = 1'b0;
                fs_dec = 1'b0;
                wait_cyc(10);
            end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // {pin[8:7], n_enc[6:5], n_dec[4:3], exp_up, exp_dout_en, exp_dec_sel}
    localparam int NSTEP = 12;
    localparam logic [8:0] STEPS [NSTEP] = '{
        {2'd0, 2'd0, 2'd0, 3'b000},  // static low, no sync: stays down
        {2'd0, 2'd0, 2'd1, 3'b100},  // decode pulse wakes, no data enable
        {2'd0, 2'd1, 2'd0, 3'b100},  // first encode pulse
        {2'd0, 2'd1, 2'd0, 3'b110},  // second encode pulse enables data
        {2'd1, 2'd0, 2'd0, 3'b000},  // static high powers down
        {2'd1, 2'd2, 2'd0, 3'b000},  // pulses blocked while high
        {2'd2, 2'd0, 2'd0, 3'b001},  // toggling: decode clock, still down
        {2'd2, 2'd1, 2'd0, 3'b101},  // wake pulse counts as first encode
        {2'd2, 2'd1, 2'd0, 3'b111},  // second encode enables data
        {2'd2, 2'd0, 2'd2, 3'b111},  // decode pulses change nothing
        {2'd1, 2'd0, 2'd0, 3'b000},  // high again: down, encode clock
        {2'd0, 2'd2, 2'd2, 3'b110}   // joint pulses: wake + count
    };

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        // R1 reset state
        check("R1", 0, powered, 1'b0);
        check("R1", 0, dout_en, 1'b0);
        check("R1", 0, aout_en, 1'b0);
        check("R1", 0, dec_sel, 1'b0);
        rst_n = 1'b1;
        wait_cyc(5);
        check("R1", 0, powered, 1'b0);

        for (int s = 0; s < NSTEP; s++) begin
            pin_mode = STEPS[s][8:7];
            wait_cyc(30);
            pulses(int'(STEPS[s][6:5]), int'(STEPS[s][4:3]));
            wait_cyc(30);
            check("R2 R5", s + 1, powered, STEPS[s][2]);
            check("R7", s + 1, dout_en, STEPS[s][1]);
            check("R3 R4", s + 1, dec_sel, STEPS[s][0]);
            check("R8", s + 1, aout_en, powered);
        end

        // R6: idle timeout, about 43 cycles already since last pulse
        wait_cyc(IDLE_CYCLES - 80);
        check("R6", 100, powered, 1'b1);
        check("R7", 100, dout_en, 1'b1);
        wait_cyc(100);
        check("R6", 101, powered, 1'b0);
        check("R7", 101, dout_en, 1'b0);
        check("R8", 101, aout_en, 1'b0);

        // R6 restart: pulses at intervals below the timeout keep it up
        pulses(0, 1);
        for (int k = 0; k < 3; k++) begin
            wait_cyc(IDLE_CYCLES - 60);
            pulses(0, 1);
        end
        check("R6", 102, powered, 1'b1);
        check("R7", 102, dout_en, 1'b0);

        // R3 + R7: single encode pulse after decode wake gives one count only
        pulses(1, 0);
        wait_cyc(10);
        check("R7", 103, dout_en, 1'b0);
        pulses(1, 0);
        wait_cyc(10);
        check("R7", 104, dout_en, 1'b1);

        finish_run();
    end
endmodule